// File: doc/BRIEF.md
# Global History Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a global outcome history: a shift register that holds the directions of the most recently resolved branches, whatever their addresses. The history selects one entry of a table of 2-bit saturating counters, and the upper bit of that counter is the guess. When `hashMode` is set, the history is XORed with word-address bits of the branch PC before it indexes the table. Unrelated branches that share a history then tend to land in different counters.

The fetch side drives the PC word bits and reads back the guess together with the table index that produced it. The guess and the index are combinational and valid in the same cycle. The pipeline carries that index along with the branch. When the branch resolves, it returns the index and the real direction on the resolve port. The counter at that index is stepped, and the outcome is shifted into the history. The history length is the parameter `HIST_W`. The default is 8, and 15 is supported. Repair of the history after a wrong path and prediction of the branch target are left to other blocks.

Top module: `ghp_predictor`

## Requirements
- R1: After reset the history is all zeros and every counter holds 01. In plain mode the first guess is not-taken with index 0.
- R2: With `hashMode` low, `predIndex` equals the current history value.
- R3: With `hashMode` high, `predIndex` equals the history XOR `predPcWord`, where `predPcWord` carries PC bits [HIST_W+1:2].
- R4: `predTaken` is the upper bit of the counter at `predIndex`. Counter values 10 and 11 mean taken; 00 and 01 mean not-taken.
- R5: A taken resolve increments the counter at `resIndex`, and a counter at 11 stays at 11.
- R6: A not-taken resolve decrements the counter at `resIndex`, and a counter at 00 stays at 00.
- R7: Each resolve shifts the history left by one. The outcome enters bit 0 (1 for taken), and the oldest bit is dropped.
- R8: The counter update uses `resIndex` exactly as supplied. No other counter changes, including the entry that the current history would select.
- R9: A guess made in the same cycle as a resolve reflects the state before that resolve.
- R10: Cycles without `resValid` change neither the history nor any counter, whatever the predict inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hashMode | input | 1 | 1 selects the history XOR PC index, 0 selects the plain history index |
| predPcWord | input | HIST_W | PC bits [HIST_W+1:2] of the branch being predicted |
| predTaken | output | 1 | Guessed direction, 1 = taken |
| predIndex | output | HIST_W | Table index used for this guess, to be returned at resolve |
| resValid | input | 1 | A branch resolves this cycle |
| resTaken | input | 1 | Real direction of the resolving branch |
| resIndex | input | HIST_W | Index that the resolving branch received at prediction time |

## Verification
A corrupted history shows up at once on `predIndex` in plain mode, because the index is the history itself. This makes each shift visible on the cycle after a resolve. A counter that steps wrongly or saturates wrongly shows up as a flipped `predTaken` only when its value crosses between 01 and 10. The bench therefore drives counters through whole up and down runs and reads any chosen entry through the hashed index. An update written to the recomputed index, instead of the returned one, changes a neighbouring entry, which a read of that entry exposes one cycle later.

// File: rtl/ghp_pkg.sv
package ghp_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic updEn;    // apply one resolve this cycle
    logic countUp;  // step direction and the history bit to shift in
  } ghp_strobe_t;

  localparam logic [1:0] CTR_RESET = 2'b01;
endpackage

// File: rtl/ghp_ctrl.sv
module ghp_ctrl
  import ghp_pkg::*;
(
  input  logic        resValid,
  input  logic        resTaken,
  output ghp_strobe_t strobe
);
  always_comb begin
    strobe.updEn   = resValid;
    strobe.countUp = resValid & resTaken;
  end
endmodule

// File: rtl/ghp_datapath.sv
module ghp_datapath
  import ghp_pkg::*;
#(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ghp_strobe_t       strobe,
  input  logic              hashMode,
  input  logic [HIST_W-1:0] predPcWord,
  input  logic [HIST_W-1:0] resIndex,
  output logic              predTaken,
  output logic [HIST_W-1:0] predIndex
);
  localparam int DEPTH = 1 << HIST_W;

  logic [HIST_W-1:0] histReg;
  logic [1:0]        phtMem [DEPTH];
  logic [1:0]        ctrCur;
  logic [1:0]        ctrNext;

  // Index forming: plain history or history hashed with PC word bits
  always_comb begin
    predIndex = hashMode ? (histReg ^ predPcWord) : histReg;
    predTaken = phtMem[predIndex][1];
  end

  // Saturating step of the counter being resolved
  always_comb begin
    ctrCur  = phtMem[resIndex];
    ctrNext = ctrCur;
    if (strobe.countUp) begin
      if (ctrCur != 2'b11) ctrNext = ctrCur + 2'd1;
    end else begin
      if (ctrCur != 2'b00) ctrNext = ctrCur - 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      histReg <= '0;
      for (int i = 0; i < DEPTH; i++) phtMem[i] <= CTR_RESET;
    end else if (strobe.updEn) begin
      histReg          <= {histReg[HIST_W-2:0], strobe.countUp};
      phtMem[resIndex] <= ctrNext;
    end
  end

  // R5: a counter at 11 stays at 11 on a taken resolve
  a_r5_sat_up: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.updEn && strobe.countUp && ctrCur == 2'b11)
      |=> phtMem[$past(resIndex)] == 2'b11);

  // R6: a counter at 00 stays at 00 on a not-taken resolve
  a_r6_sat_down: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.updEn && !strobe.countUp && ctrCur == 2'b00)
      |=> phtMem[$past(resIndex)] == 2'b00);

  // R7: the history shifts by one and takes the outcome into bit 0
  a_r7_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.updEn |=> histReg == {$past(histReg[HIST_W-2:0]), $past(strobe.countUp)});

  // R10: no resolve, no change to the history
  a_r10_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.updEn |=> $stable(histReg));

  // R2: in plain mode the index follows the history register
  a_r2_plain_index: assert property (@(posedge clk) disable iff (!rst_n)
    (!hashMode && strobe.updEn) |=> ##0 (hashMode || predIndex == histReg));
endmodule

// File: rtl/ghp_predictor.sv
module ghp_predictor
  import ghp_pkg::*;
#(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hashMode,
  input  logic [HIST_W-1:0] predPcWord,
  output logic              predTaken,
  output logic [HIST_W-1:0] predIndex,
  input  logic              resValid,
  input  logic              resTaken,
  input  logic [HIST_W-1:0] resIndex
);
  ghp_strobe_t strobe;

  ghp_ctrl u_ctrl (
    .resValid (resValid),
    .resTaken (resTaken),
    .strobe   (strobe)
  );

  ghp_datapath #(.HIST_W(HIST_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .hashMode   (hashMode),
    .predPcWord (predPcWord),
    .resIndex   (resIndex),
    .predTaken  (predTaken),
    .predIndex  (predIndex)
  );
endmodule

// File: tb/ghp_predictor_tb.sv
module ghp_predictor_tb;
  localparam int W = 8;
  localparam int D = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         hashMode = 1'b0;
  logic [W-1:0] predPcWord = '0;
  logic         predTaken;
  logic [W-1:0] predIndex;
  logic         resValid = 1'b0;
  logic         resTaken = 1'b0;
  logic [W-1:0] resIndex = '0;

  int nChecks = 0;
  int nErrors = 0;

  logic [W-1:0] mHist;
  logic [1:0]   mCtr [D];

  always #5 clk = ~clk;

  ghp_predictor #(.HIST_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .hashMode(hashMode), .predPcWord(predPcWord),
    .predTaken(predTaken), .predIndex(predIndex),
    .resValid(resValid), .resTaken(resTaken), .resIndex(resIndex)
  );

  task automatic chk(string req, int got, int exp);
    nChecks++;
    if (got != exp) begin
      nErrors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Model update from the requirements (R5, R6, R7)
  task automatic resolve(logic [W-1:0] idx, logic tk);
    resValid = 1'b1; resIndex = idx; resTaken = tk;
    @(posedge clk);
    if (tk && mCtr[idx] != 2'b11) mCtr[idx] = mCtr[idx] + 2'd1;
    if (!tk && mCtr[idx] != 2'b00) mCtr[idx] = mCtr[idx] - 2'd1;
    mHist = {mHist[W-2:0], tk};
    @(negedge clk);
    resValid = 1'b0;
  endtask

  // Read any counter through the hashed index (R3, R4)
  task automatic peek(string req, logic [W-1:0] k);
    hashMode = 1'b1; predPcWord = k ^ mHist;
    #1;
    chk({req, " index"}, int'(predIndex), int'(k));
    chk({req, " taken"}, int'(predTaken), int'(mCtr[k][1]));
  endtask

  task automatic t_reset;
    hashMode = 1'b0; predPcWord = 8'hC3; #1;
    chk("R1 index", int'(predIndex), 0);
    chk("R1 taken", int'(predTaken), 0);
    hashMode = 1'b1; predPcWord = 8'h5A; #1;
    chk("R3 reset hash", int'(predIndex), 'h5A);
    peek("R1 entry FF", 8'hFF);
  endtask

  task automatic t_count_up;
    resolve(8'h33, 1'b1);            // 01 -> 10
    peek("R4 after one taken", 8'h33);
    chk("R5 taken from 01", int'(predTaken), 1);
    resolve(8'h33, 1'b1); resolve(8'h33, 1'b1); resolve(8'h33, 1'b1);
    resolve(8'h33, 1'b0);            // saturated 11 -> 10
    peek("R5 saturate high", 8'h33);
    chk("R5 still taken", int'(predTaken), 1);
    resolve(8'h33, 1'b0);            // 10 -> 01
    peek("R6 back to not-taken", 8'h33);
  endtask

  task automatic t_count_down;
    resolve(8'h71, 1'b0); resolve(8'h71, 1'b0); resolve(8'h71, 1'b0);
    resolve(8'h71, 1'b1); resolve(8'h71, 1'b1);   // 00 -> 10 when saturating
    peek("R6 saturate low", 8'h71);
    chk("R6 two taken from 00", int'(predTaken), 1);
  endtask

  task automatic t_history;
    logic [W-1:0] pat;
    pat = 8'b1011_0010;
    for (int i = W - 1; i >= 0; i--) resolve(8'h00, pat[i]);
    hashMode = 1'b0; #1;
    chk("R7 full pattern", int'(predIndex), int'(pat));
    chk("R2 plain index", int'(predIndex), int'(mHist));
    resolve(8'h00, 1'b1);            // oldest bit dropped
    hashMode = 1'b0; #1;
    chk("R7 oldest dropped", int'(predIndex), 'h65);
  endtask

  task automatic t_isolation;
    logic [W-1:0] cur;
    cur = mHist;
    resolve(8'h10, 1'b1);
    resolve(8'h10, 1'b1);
    peek("R8 supplied entry", 8'h10);
    chk("R8 supplied entry taken", int'(predTaken), 1);
    peek("R8 history entry untouched", cur);
    peek("R8 next history entry", {cur[W-2:0], 1'b1});
  endtask

  task automatic t_same_cycle;
    logic [W-1:0] oldHist;
    logic         oldBit;
    oldHist = mHist;
    hashMode = 1'b1; predPcWord = 8'h22 ^ mHist;
    oldBit = mCtr[8'h22][1];
    resValid = 1'b1; resIndex = 8'h22; resTaken = 1'b1;
    #1;
    chk("R9 old index", int'(predIndex), 'h22);
    chk("R9 old taken", int'(predTaken), int'(oldBit));
    @(posedge clk);
    mCtr[8'h22] = 2'b10;
    mHist = {oldHist[W-2:0], 1'b1};
    @(negedge clk);
    resValid = 1'b0;
    peek("R9 after edge", 8'h22);
    chk("R9 updated taken", int'(predTaken), 1);
  endtask

  task automatic t_idle;
    logic [W-1:0] h;
    h = mHist;
    for (int i = 0; i < 6; i++) begin
      hashMode = i[0]; predPcWord = W'(i * 37);
      resTaken = 1'b1; resIndex = 8'h40;
      @(negedge clk);
    end
    hashMode = 1'b0; #1;
    chk("R10 history held", int'(predIndex), int'(h));
    peek("R10 entry 40 held", 8'h40);
    peek("R10 entry 33 held", 8'h33);
  endtask

  initial begin
    #2000000;
    nErrors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    mHist = '0;
    for (int i = 0; i < D; i++) mCtr[i] = 2'b01;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count_up();
    t_count_down();
    t_history();
    t_isolation();
    t_same_cycle();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule